// File: doc/BRIEF.md
# Serial Double-Word Shift and Normalize Unit

This unit holds two 24-bit words, A and B, and treats them as a single 48-bit value with A in the upper half. A command selects one of five operations: arithmetic right shift, logical left shift, right rotate, left rotate, or normalize. Each command also carries a position count and a starting value for a 14-bit index register. The value moves one bit position per clock, so the latency depends on the count. An operation takes two fixed cycles plus one cycle for each position moved.

Normalize shifts the pair left until the two top bits of A differ, or until the count runs out. It decrements the index once for every position actually shifted, so that afterwards the index holds the exponent adjustment. The caller pulses `start_i` while the unit is idle. It then waits for the one-cycle `done_o` pulse and reads A, B and the index from the outputs.

Top module: `ab_shift_unit`

## Requirements
- R1: After reset, or whenever `rst_ni` is low, `a_o`, `b_o` and `x_o` are zero and `busy_o` and `done_o` are low.
- R2: Op code 0 shifts the 48-bit pair right one place per step. The top bit (A bit 23) keeps its value, and A bit 0 moves into B bit 23.
- R3: Op code 2 shifts the pair left one place per step. A zero enters B bit 0, and B bit 23 moves into A bit 0.
- R4: Op code 1 rotates the pair right and op code 3 rotates it left, both over all 48 bits, so that the bit leaving one end enters the other end.
- R5: Op code 4 (normalize) shifts left as in R3. Before each step it stops if A bit 23 differs from A bit 22, and otherwise stops after `count_i` steps. The index decreases by one per step performed and wraps modulo 2^14, so an all-zero pair takes all `count_i` steps.
- R6: If start is accepted at clock edge e, `done_o` is high for exactly the one cycle that follows edge e+1+k, where k is the number of steps performed. k is `count_i`, or the normalize step count of R5. After that cycle, `busy_o` is low.
- R7: A count of zero leaves A, B and the index unchanged, and `done_o` rises in the second cycle after start.
- R8: Counts of 48 or more saturate a shift: a right shift leaves all copies of the sign and a left shift leaves all zeros. A rotate ends at the same value as a rotate by the count modulo 48, but it still takes 2+count cycles.
- R9: `start_i` is ignored while `busy_o` is high, and the running operation completes with its original operands.
- R10: Op codes 5 to 7 leave A, B and the index unchanged, and complete in two cycles whatever the count.
- R11: Every operation other than normalize leaves the index at the value loaded with the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command strobe, taken when idle |
| op_i | input | 3 | Operation code (0 rsh, 1 rcy, 2 lsh, 3 lcy, 4 normalize) |
| count_i | input | 8 | Number of positions |
| a_i | input | 24 | Upper word operand |
| b_i | input | 24 | Lower word operand |
| x_i | input | 14 | Index register start value |
| a_o | output | 24 | Upper word result |
| b_o | output | 24 | Lower word result |
| x_o | output | 14 | Index register result |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench drives counts past 48 and up to 255. A unit that wrapped the count or masked it to six bits would leave stray bits behind in a shift, and would finish too early on a long rotate. Normalize is run on an operand that is already normalized, on a negative operand, on an all-zero pair whose index wraps below zero, and on a count that runs out before the pair is normalized. An off-by-one in the stop test would show up as a wrong index or a latency that is one cycle off. Zero counts, unsupported op codes, a start pulse during a running operation and a reset in the middle of an operation each catch a unit that moves data, restarts or stays busy when it must not.

// File: rtl/dsu_pkg.sv
package dsu_pkg;
  typedef enum logic [2:0] {
    OP_RSH = 3'd0,
    OP_RCY = 3'd1,
    OP_LSH = 3'd2,
    OP_LCY = 3'd3,
    OP_NRM = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PREP  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_FIN   = 2'd3
  } st_e;

  localparam int unsigned OP_LAST = 4;
endpackage

// File: rtl/dsu_step.sv
// One-position move of the joined register pair.
module dsu_step #(
  parameter int unsigned DW = 48
) (
  input  logic [2:0]    op_i,
  input  logic [DW-1:0] val_i,
  output logic [DW-1:0] val_o
);
  import dsu_pkg::*;

  always_comb begin
    unique case (op_i)
      OP_RSH:  val_o = {val_i[DW-1], val_i[DW-1:1]};
      OP_RCY:  val_o = {val_i[0], val_i[DW-1:1]};
      OP_LSH,
      OP_NRM:  val_o = {val_i[DW-2:0], 1'b0};
      OP_LCY:  val_o = {val_i[DW-2:0], val_i[DW-1]};
      default: val_o = val_i;
    endcase
  end
endmodule

// File: rtl/dsu_norm_det.sv
// Flags a value whose two top bits differ; one copy per probe point.
module dsu_norm_det #(
  parameter int unsigned DW    = 48,
  parameter int unsigned PORTS = 2
) (
  input  logic [PORTS-1:0][DW-1:0] val_i,
  output logic [PORTS-1:0]         norm_o
);
  for (genvar g = 0; g < PORTS; g++) begin : g_det
    assign norm_o[g] = val_i[g][DW-1] ^ val_i[g][DW-2];
  end
endmodule

// File: rtl/dsu_ctrl.sv
module dsu_ctrl #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             op_ok_i,
  input  logic             nrm_i,
  input  logic             norm_now_i,
  input  logic             norm_next_i,
  output logic             load_o,
  output logic             step_o,
  output logic             busy_o,
  output logic             done_o
);
  import dsu_pkg::*;

  st_e              st_q, st_d;
  logic [CNT_W-1:0] rem_q, rem_d;

  assign load_o = (st_q == ST_IDLE) && start_i;
  assign step_o = (st_q == ST_SHIFT);
  assign busy_o = (st_q != ST_IDLE);
  assign done_o = (st_q == ST_FIN);

  always_comb begin
    st_d  = st_q;
    rem_d = rem_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d  = ST_PREP;
          rem_d = count_i;
        end
      end
      ST_PREP: begin
        if (!op_ok_i || rem_q == '0 || (nrm_i && norm_now_i)) st_d = ST_FIN;
        else                                                   st_d = ST_SHIFT;
      end
      ST_SHIFT: begin
        rem_d = rem_q - 1'b1;
        if (rem_d == '0 || (nrm_i && norm_next_i)) st_d = ST_FIN;
      end
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      rem_q <= '0;
    end else begin
      st_q  <= st_d;
      rem_q <= rem_d;
    end
  end
endmodule

// File: rtl/ab_shift_unit.sv
module ab_shift_unit #(
  parameter int unsigned WORD_W = 24,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned IDX_W  = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic [IDX_W-1:0]  x_i,
  output logic [WORD_W-1:0] a_o,
  output logic [WORD_W-1:0] b_o,
  output logic [IDX_W-1:0]  x_o,
  output logic              busy_o,
  output logic              done_o
);
  import dsu_pkg::*;

  localparam int unsigned PAIR_W = 2 * WORD_W;

  logic [PAIR_W-1:0] ab_q, ab_nx;
  logic [IDX_W-1:0]  x_q;
  logic [2:0]        op_q;
  logic              op_ok_q;
  logic              load, step;
  logic [1:0]        norm_flags;

  dsu_step #(.DW(PAIR_W)) u_step (
    .op_i  (op_q),
    .val_i (ab_q),
    .val_o (ab_nx)
  );

  dsu_norm_det #(.DW(PAIR_W), .PORTS(2)) u_norm (
    .val_i  ({ab_nx, ab_q}),
    .norm_o (norm_flags)
  );

  dsu_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .count_i     (count_i),
    .op_ok_i     (op_ok_q),
    .nrm_i       (op_q == OP_NRM),
    .norm_now_i  (norm_flags[0]),
    .norm_next_i (norm_flags[1]),
    .load_o      (load),
    .step_o      (step),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ab_q    <= '0;
      x_q     <= '0;
      op_q    <= '0;
      op_ok_q <= 1'b0;
    end else if (load) begin
      ab_q    <= {a_i, b_i};
      x_q     <= x_i;
      op_q    <= op_i;
      op_ok_q <= (32'(op_i) <= OP_LAST);
    end else if (step) begin
      ab_q <= ab_nx;
      if (op_q == OP_NRM) x_q <= x_q - 1'b1;
    end
  end

  assign a_o = ab_q[PAIR_W-1:WORD_W];
  assign b_o = ab_q[WORD_W-1:0];
  assign x_o = x_q;
endmodule

// File: rtl/ab_shift_unit_chk.sv
module ab_shift_unit_chk #(
  parameter int unsigned WORD_W = 24,
  parameter int unsigned IDX_W  = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic [WORD_W-1:0] a_o,
  input logic [WORD_W-1:0] b_o,
  input logic [IDX_W-1:0]  x_o,
  input logic [2:0]        op_q
);
  import dsu_pkg::*;

  logic [IDX_W-1:0] one_x;
  assign one_x = {{(IDX_W-1){1'b0}}, 1'b1};

  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_done_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  a_r9_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);

  a_r2_sign_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && op_q == OP_RSH) |=> (a_o[WORD_W-1] == $past(a_o[WORD_W-1])));

  a_r4_ones_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && (op_q == OP_RCY || op_q == OP_LCY))
    |=> ($countones({a_o, b_o}) == $past($countones({a_o, b_o}))));

  a_r5_x_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && op_q == OP_NRM)
    |=> (x_o == $past(x_o) || x_o == ($past(x_o) - one_x)));

  a_r11_x_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && op_q != OP_NRM) |=> $stable(x_o));
endmodule

bind ab_shift_unit ab_shift_unit_chk #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .busy_o (busy_o),
  .done_o (done_o),
  .a_o    (a_o),
  .b_o    (b_o),
  .x_o    (x_o),
  .op_q   (op_q)
);

// File: tb/ab_shift_unit_tb.sv
module ab_shift_unit_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0]  op;
    logic [7:0]  n;
    logic [23:0] a;
    logic [23:0] b;
    logic [13:0] x;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 8'd5,   24'h800F00, 24'h000123, 14'h0011, 8'd2},   // R2
    '{3'd0, 8'd50,  24'h812345, 24'h00ABCD, 14'h0022, 8'd8},   // R8 rsh negative
    '{3'd0, 8'd60,  24'h412345, 24'hFFFFFF, 14'h0033, 8'd8},   // R8 rsh positive
    '{3'd2, 8'd7,   24'h00F00F, 24'hC00001, 14'h0044, 8'd3},   // R3
    '{3'd2, 8'd48,  24'hFFFFFF, 24'hFFFFFF, 14'h0055, 8'd8},   // R8 lsh
    '{3'd1, 8'd13,  24'h123456, 24'h789ABC, 14'h0066, 8'd4},   // R4
    '{3'd3, 8'd49,  24'h800000, 24'h000001, 14'h0077, 8'd8},   // R8 lcy
    '{3'd1, 8'd48,  24'hA5A5A5, 24'h5A5A5A, 14'h0088, 8'd8},   // R8 rcy full turn
    '{3'd3, 8'd24,  24'h123456, 24'hABCDEF, 14'h0099, 8'd4},   // R4 swap halves
    '{3'd4, 8'd30,  24'h000123, 24'h456789, 14'h0100, 8'd5},   // R5
    '{3'd4, 8'd10,  24'h000000, 24'h000000, 14'h0003, 8'd5},   // R5 zero, x wraps
    '{3'd4, 8'd20,  24'h400000, 24'h000001, 14'h0200, 8'd5},   // R5 already normal
    '{3'd4, 8'd40,  24'hFFF000, 24'h000000, 14'h0040, 8'd5},   // R5 negative
    '{3'd4, 8'd3,   24'h000001, 24'h000000, 14'h0005, 8'd5},   // R5 count limit
    '{3'd2, 8'd0,   24'h13579B, 24'h2468AC, 14'h0123, 8'd7},   // R7
    '{3'd5, 8'd9,   24'hDEADBE, 24'h00C0DE, 14'h0abc, 8'd10},  // R10
    '{3'd7, 8'd30,  24'h0F0F0F, 24'hF0F0F0, 14'h1234, 8'd10},  // R10
    '{3'd3, 8'd255, 24'hC00003, 24'h800001, 14'h0321, 8'd8}    // R8 long rotate
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [7:0]  count_i = '0;
  logic [23:0] a_i = '0, b_i = '0;
  logic [13:0] x_i = '0;
  logic [23:0] a_o, b_o;
  logic [13:0] x_o;
  logic        busy_o, done_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ab_shift_unit u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .op_i    (op_i),
    .count_i (count_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .x_i     (x_i),
    .a_o     (a_o),
    .b_o     (b_o),
    .x_o     (x_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  task automatic chk(input bit ok, input int req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference behaviour from the requirements.
  function automatic void model(input logic [2:0] op, input logic [7:0] n,
                                input logic [47:0] ab_in, input logic [13:0] x_in,
                                output logic [47:0] ab, output logic [13:0] x,
                                output int k);
    ab = ab_in;
    x  = x_in;
    k  = 0;
    if (op > 3'd4) return;
    for (int i = 0; i < int'(n); i++) begin
      if (op == 3'd4 && ab[47] != ab[46]) break;
      case (op)
        3'd0: ab = {ab[47], ab[47:1]};
        3'd1: ab = {ab[0], ab[47:1]};
        3'd3: ab = {ab[46:0], ab[47]};
        default: ab = {ab[46:0], 1'b0};
      endcase
      if (op == 3'd4) x = x - 14'd1;
      k++;
    end
  endfunction

  task automatic run_vec(input vec_t v);
    logic [47:0] eab;
    logic [13:0] ex;
    int k;
    int cyc;
    int req;
    req = int'(v.req);
    model(v.op, v.n, {v.a, v.b}, v.x, eab, ex, k);
    @(negedge clk);
    start_i = 1'b1; op_i = v.op; count_i = v.n; a_i = v.a; b_i = v.b; x_i = v.x;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 1;
    while (!done_o && cyc < 600) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == 2 + k, req, "latency (R6)", 64'(cyc), 64'(2 + k));
    chk(a_o == eab[47:24], req, "A word", 64'(a_o), 64'(eab[47:24]));
    chk(b_o == eab[23:0], req, "B word", 64'(b_o), 64'(eab[23:0]));
    chk(x_o == ex, req, "index (R11 when not normalize)", 64'(x_o), 64'(ex));
    @(negedge clk);
    chk(!done_o && !busy_o, 6, "R6 done single cycle then idle",
        64'({done_o, busy_o}), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [47:0] eab;
    logic [13:0] ex;
    int k;
    int cyc;

    // R1 reset state
    #(CLK_PERIOD * 2 + 1);
    chk(a_o == 0 && b_o == 0 && x_o == 0, 1, "R1 regs in reset",
        {a_o, b_o, x_o[13:0] & 14'h3fff} >> 14, 64'd0);
    chk(!busy_o && !done_o, 1, "R1 flags in reset", 64'({busy_o, done_o}), 64'd0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R9 start while busy is ignored
    model(3'd2, 8'd10, {24'h000001, 24'h000000}, 14'h0007, eab, ex, k);
    @(negedge clk);
    start_i = 1'b1; op_i = 3'd2; count_i = 8'd10; a_i = 24'h000001; b_i = '0; x_i = 14'h0007;
    @(negedge clk);
    start_i = 1'b0; cyc = 1;
    repeat (3) begin @(negedge clk); cyc++; end
    start_i = 1'b1; op_i = 3'd4; count_i = 8'd2; a_i = 24'hFFFFFF; b_i = 24'hFFFFFF; x_i = 14'h3333;
    @(negedge clk);
    start_i = 1'b0; cyc++;
    while (!done_o && cyc < 600) begin @(negedge clk); cyc++; end
    chk(cyc == 2 + k, 9, "R9 latency", 64'(cyc), 64'(2 + k));
    chk({a_o, b_o} == eab, 9, "R9 pair", 64'({a_o, b_o}), 64'(eab));
    chk(x_o == ex, 9, "R9 index", 64'(x_o), 64'(ex));
    @(negedge clk);

    // R1 reset in the middle of an operation
    @(negedge clk);
    start_i = 1'b1; op_i = 3'd1; count_i = 8'd100; a_i = 24'h123456; b_i = 24'h654321; x_i = 14'h0abc;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk(a_o == 0 && b_o == 0 && x_o == 0, 1, "R1 regs after mid-op reset",
        64'({a_o, b_o}), 64'd0);
    chk(!busy_o && !done_o, 1, "R1 flags after mid-op reset",
        64'({busy_o, done_o}), 64'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!busy_o, 1, "R1 stays idle after release", 64'(busy_o), 64'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule